// File: doc/BRIEF.md
# Audio Master Clock Divider

This block lets a serial audio port run as clock master when the audio master clock is synchronous to that port. It divides the master clock into a bit clock and a left/right word clock. A two-bit ratio select picks 256, 512 or 768 master clocks per sample period. The bit clock is fixed at 64 bit periods per sample, so one bit period lasts 4, 8 or 12 master clocks.

Either the input port or the output port may use one instance as its master timing source. When master operation is off, both clocks are held low so that the port can be driven by an external master. A new ratio is taken up only at a word clock edge, so a mode change never produces a short or stretched pulse inside a word phase.

Top module: `audclk_master_div`

## Requirements
- R1: While reset is asserted (sampled low at a clock edge), both bclk_o and wclk_o are low. After reset is released with enable high, the first bclk_o rise happens exactly half-period master clocks later (2, 4 or 6 for the selected ratio).
- R2: Each high and each low level of bclk_o lasts exactly ratio/128 master clocks: 2 for 256x, 4 for 512x, 6 for 768x.
- R3: Each high and each low level of wclk_o lasts exactly 32 bit clock periods, that is 64 times the bclk_o half period, giving 50 percent duty.
- R4: wclk_o changes only in the same master clock cycle in which bclk_o falls.
- R5: Ratio select encoding: 0 selects 256x, 1 selects 512x, 2 selects 768x, and the value 3 also selects 256x.
- R6: A ratio select change made while running takes effect only at the next wclk_o edge; every bclk_o level before that edge keeps the old length, and every level after it has the new length.
- R7: When master_en_i is low at a clock edge, both outputs are low after that edge and stay low, whatever ratio_sel_i does.
- R8: After reset, and after master_en_i rises, wclk_o starts low (left channel phase) and the first bclk_o rise follows after exactly one half period of the ratio selected while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Audio master clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| master_en_i | input | 1 | High to drive the port as clock master |
| ratio_sel_i | input | 2 | Master clocks per sample: 0=256, 1=512, 2=768, 3=256 |
| bclk_o | output | 1 | Bit clock, 64 periods per sample |
| wclk_o | output | 1 | Left/right word clock, low for the left channel |

## Verification
The bench measures the length of every bclk_o and wclk_o level for all four select codes, so a divider that miscounts the 768x case by one (a 5 or 7 cycle half period) or a word clock that toggles every 31 or 33 bits shows up as a wrong run length. The mode change test switches the ratio in the middle of a word phase; a design that applied it at once would shorten or stretch the remaining bit levels before the word edge. Disabling mid-frame and re-enabling checks that outputs fall low at once and that a restart begins with a full half period in the left phase; a design that kept the old count would emit a short first pulse. The edge alignment of the two clocks is checked on every sample, which catches a word clock that moves on a rising bit clock edge.

// File: rtl/audclk_pkg.sv
// Package: shared ratio encoding and half-period lookup for the master
// clock divider. Assumes the bit clock runs at 64 periods per sample.
package audclk_pkg;

    typedef enum logic [1:0] {
        RSEL_X256 = 2'd0,
        RSEL_X512 = 2'd1,
        RSEL_X768 = 2'd2,
        RSEL_ALT  = 2'd3
    } ratio_sel_e;

    localparam int unsigned HALF_W = 3;

    // Master clocks per bit clock level for a given select code.
    function automatic logic [HALF_W-1:0] half_of(input logic [1:0] sel);
        case (sel)
            RSEL_X512: half_of = 3'd4;
            RSEL_X768: half_of = 3'd6;
            default:   half_of = 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/audclk_ratio_hold.sv
// Module: holds the active bit half-period length. Follows the select input
// freely while in reset or idle; while running it only updates at a word
// clock boundary. Assumes boundary_i is a single-cycle pulse.
module audclk_ratio_hold
    import audclk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [1:0]        sel_i,
    input  logic              boundary_i,
    output logic [HALF_W-1:0] half_o
);

    logic [HALF_W-1:0] half_q;

    // Load the requested ratio when idle or at a word clock edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i || boundary_i) begin
            half_q <= half_of(sel_i);
        end
    end

    assign half_o = half_q;

    // R6: the active ratio moves only at a boundary, in reset or when idle.
    assert_ratio_at_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(half_q) |-> ($past(boundary_i) || $past(!en_i) || $past(!rst_ni)));

endmodule

// File: rtl/audclk_prescale.sv
// Module: counts master clocks within one bit clock level and pulses tick_o
// on the last one. Assumes half_i is at least 2 and only changes at a tick.
module audclk_prescale
    import audclk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              tick_o
);

    logic [HALF_W-1:0] pre_q;
    logic              last;

    assign last   = (pre_q == half_i - 1'b1);
    assign tick_o = en_i && last;

    // Advance the level counter, wrapping on the last master clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            pre_q <= '0;
        end else if (last) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R2: the level counter never reaches the active half-period length.
    assert_pre_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_q < half_i);

endmodule

// File: rtl/audclk_frame_cnt.sv
// Module: counts bit clock half periods across one sample frame and derives
// both output clocks from single flops. Assumes FRAME_BITS is a power of two.
module audclk_frame_cnt #(
    parameter int unsigned FRAME_BITS = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic tick_i,
    output logic bclk_o,
    output logic wclk_o,
    output logic boundary_o
);

    localparam int unsigned HP_W = $clog2(2 * FRAME_BITS);

    logic [HP_W-1:0] hp_q;

    // Step the half-period count on each prescaler tick; clear when idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            hp_q <= '0;
        end else if (tick_i) begin
            hp_q <= hp_q + 1'b1;
        end
    end

    assign bclk_o     = hp_q[0];
    assign wclk_o     = hp_q[HP_W-1];
    assign boundary_o = tick_i && (&hp_q[HP_W-2:0]);

    // R4: the word clock moves only together with a falling bit clock.
    assert_word_on_bfall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(wclk_o) |-> $fell(bclk_o));

    // R2: the bit clock moves only after a tick or when going idle.
    assert_bit_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(bclk_o) |-> ($past(tick_i) || $past(!en_i)));

endmodule

// File: rtl/audclk_master_div.sv
// Module: audio master clock divider top. Produces bit and word clocks for a
// serial port at 256x, 512x or 768x of the sample rate. Assumes clk_i is the
// master clock and all inputs are synchronous to it; outputs are flop driven.
module audclk_master_div
    import audclk_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 64
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       master_en_i,
    input  logic [1:0] ratio_sel_i,
    output logic       bclk_o,
    output logic       wclk_o
);

    logic [HALF_W-1:0] half;
    logic              tick;
    logic              boundary;

    audclk_ratio_hold u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (master_en_i),
        .sel_i      (ratio_sel_i),
        .boundary_i (boundary),
        .half_o     (half)
    );

    audclk_prescale u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (master_en_i),
        .half_i (half),
        .tick_o (tick)
    );

    audclk_frame_cnt #(
        .FRAME_BITS (FRAME_BITS)
    ) u_frame (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (master_en_i),
        .tick_i     (tick),
        .bclk_o     (bclk_o),
        .wclk_o     (wclk_o),
        .boundary_o (boundary)
    );

    // R7: an idle cycle leaves both clocks low after the edge.
    assert_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !master_en_i |=> (!bclk_o && !wclk_o));

    // R1: reset holds both clocks low.
    assert_reset_low_R1: assert property (@(posedge clk_i)
        $past(!rst_ni) |-> (!bclk_o && !wclk_o));

endmodule

// File: tb/test_audclk_master_div.sv
module test_audclk_master_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       bclk;
    logic       wclk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    audclk_master_div i_audclk_master_div (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .master_en_i (en),
        .ratio_sel_i (sel),
        .bclk_o      (bclk),
        .wclk_o      (wclk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measure the length of the current bclk level, sample by sample.
    task automatic bit_run(output int len);
        logic lvl;
        lvl = bclk;
        len = 1;
        @(negedge clk);
        while (bclk == lvl && len < 2000) begin
            len++;
            @(negedge clk);
        end
    endtask

    // Measure the current wclk level, counting edge misalignment on the way.
    task automatic word_run(output int len, inout int bad);
        logic lvl, pb, pw;
        lvl = wclk;
        len = 1;
        pb = bclk;
        pw = wclk;
        @(negedge clk);
        while (len < 5000) begin
            if (wclk != pw && !(pb == 1'b1 && bclk == 1'b0)) bad++;
            pb = bclk;
            pw = wclk;
            if (wclk != lvl) break;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic wait_word_edge();
        logic w0;
        w0 = wclk;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (wclk != w0) break;
        end
    endtask

    task automatic count_first_rise(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (bclk == 1'b0 && k < 100);
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b1;
        sel = s;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        int k;
        do_reset(2'd0);
        check(!bclk && !wclk, "R1 outputs low in reset", {bclk, wclk}, 0);
        rst_n = 1'b1;
        count_first_rise(k);
        check(k == 2, "R1 first bclk rise after reset", k, 2);
        check(wclk == 1'b0, "R8 left phase after reset", wclk, 0);
    endtask

    task automatic test_ratio(input logic [1:0] s, input int half);
        int k, len, bad, mism;
        do_reset(s);
        rst_n = 1'b1;
        count_first_rise(k);
        check(k == half, "R8 first rise after reset per ratio", k, half);
        mism = 0;
        for (int i = 0; i < 8; i++) begin
            bit_run(len);
            if (len != half) mism++;
        end
        check(mism == 0, "R2 R5 bclk level length", mism, 0);
        wait_word_edge();
        bad = 0;
        word_run(len, bad);
        check(len == 64 * half, "R3 wclk level length", len, 64 * half);
        word_run(len, bad);
        check(len == 64 * half, "R3 wclk second level length", len, 64 * half);
        check(bad == 0, "R4 wclk moves with bclk fall", bad, 0);
    endtask

    task automatic test_mode_change(input logic [1:0] s_old, input int h_old,
                                    input logic [1:0] s_new, input int h_new);
        int len, mism;
        logic w0;
        do_reset(s_old);
        rst_n = 1'b1;
        wait_word_edge();
        w0 = wclk;
        mism = 0;
        for (int i = 0; i < 64; i++) begin
            if (i == 10) sel = s_new;
            bit_run(len);
            if (len != h_old) mism++;
        end
        check(mism == 0, "R6 old ratio kept until word edge", mism, 0);
        check(wclk != w0, "R6 word edge reached after 64 levels", wclk, !w0);
        mism = 0;
        for (int i = 0; i < 6; i++) begin
            bit_run(len);
            if (len != h_new) mism++;
        end
        check(mism == 0, "R6 new ratio after word edge", mism, 0);
    endtask

    task automatic test_disable();
        int k, highs;
        do_reset(2'd1);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!bclk && !wclk, "R7 outputs low after disable", {bclk, wclk}, 0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            sel = 2'(i);
            @(negedge clk);
            if (bclk || wclk) highs++;
        end
        check(highs == 0, "R7 held low while idle", highs, 0);
        sel = 2'd2;
        @(negedge clk);
        en = 1'b1;
        count_first_rise(k);
        check(k == 6, "R8 first rise after re-enable", k, 6);
        check(wclk == 1'b0, "R8 left phase after re-enable", wclk, 0);
    endtask

    initial begin
        test_reset();
        test_ratio(2'd0, 2);
        test_ratio(2'd1, 4);
        test_ratio(2'd2, 6);
        test_ratio(2'd3, 2);
        test_mode_change(2'd0, 2, 2'd2, 6);
        test_mode_change(2'd2, 6, 2'd1, 4);
        test_disable();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule